// File: doc/BRIEF.md
# Two-Wire CAN Bus Fault Detector

This block is the digital fault classifier of a fault-tolerant low-speed CAN transceiver. Each clock it takes the sampled dominant/recessive state of the high and low bus wires, six comparator condition flags from the analog front end, and the transmit data bit. It turns these into registered fault flags. From those flags it chooses which wires the receiver and the line drivers may use.

Faults come to light in two ways. A wire that is open or stuck recessive stops producing dominant-to-recessive transitions. A signed difference counter measures how far the two wires' transition counts drift apart. Each comparator condition goes through its own time filter, which has separate qualify and release times in clock ticks.

When one wire is judged faulty, the block falls back to single-wire operation on the other wire. When no wire can be used, the receive output stays recessive. A transmit input that stays dominant for too long blocks both drivers until the input has been recessive for a short release time.

Top module: `canbus_fault_monitor`

## Requirements
- R1: After reset, all eight fault flags are clear, the wire mode is 0 (dual), the transmit block is off and the receive output is recessive.
- R2: Comparator condition i (0 high-to-battery, 1 low-to-ground, 2 low-to-battery, 3 high-to-logic-supply, 4 wires crossed, 5 overvoltage) sets fault_flags[i] on the clock edge that sees it for the DET_T[i]-th consecutive time. Any cycle without the condition restarts the count.
- R3: A set comparator flag clears on the clock edge that sees its condition absent for the REC_T[i]-th consecutive time. A cycle with the condition present restarts that count.
- R4: fault_flags[6] (high wire lost) sets when the low wire has shown more than EDGE_LIMIT (default 3) more dominant-to-recessive transitions than the high wire. fault_flags[7] (low wire lost) sets in the mirror case. Simultaneous transitions on both wires leave the difference unchanged.
- R5: An edge-count fault clears after EDGE_RECOV (default 3) dominant-to-recessive transitions on the failed wire. The difference then restarts from zero.
- R6: wire_mode is 0 with no fault. It is 2 (low wire only) when a high-wire fault (flags 0, 3, 6) is set. It is 1 (high wire only) when a low-wire fault (flags 1, 2, 4, 7) is set. It is 3 (no wire) when faults on both sides are set or when flag 5 is set.
- R7: rx_dom is the OR of the dominant states of the wires that the current mode allows. In mode 3 it is recessive (0).
- R8: drv_h and drv_l follow txd_dom only for wires that the mode allows, and both are 0 while the transmit block is on.
- R9: tx_blocked sets on the edge that sees txd_dom dominant for the TX_LIMIT-th consecutive time.
- R10: tx_blocked clears on the edge that sees txd_dom recessive for the TX_REC-th consecutive time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter tick clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| canh_dom | input | 1 | Sampled high wire state, 1 = dominant |
| canl_dom | input | 1 | Sampled low wire state, 1 = dominant |
| cmp_cond | input | 6 | Comparator fault conditions, indices as in R2 |
| txd_dom | input | 1 | Transmit data, 1 = dominant |
| fault_flags | output | 8 | Qualified faults: bits 0-5 comparators, 6 high lost, 7 low lost |
| wire_mode | output | 2 | 0 dual, 1 high only, 2 low only, 3 none |
| rx_dom | output | 1 | Receive data, 1 = dominant |
| drv_h | output | 1 | High wire driver enable |
| drv_l | output | 1 | Low wire driver enable |
| tx_blocked | output | 1 | Transmitter disabled after dominant timeout |

## Verification
The hardest state to reach from the ports is an edge-count fault followed by its recovery. The bench builds it by pulsing only one wire, one pulse at a time, and checks the flag after the fourth unmatched transition but not after the third. It then pulses the failed wire to recover. Three more one-sided pulses must then leave the flag clear, which shows the difference restarted at zero. Glitches that cut a qualify window one cycle short, and a condition that comes back partway through a release window, show that the counts restart.

// File: rtl/cbfm_pkg.sv
`timescale 1ns/1ps
package cbfm_pkg;
   localparam int NCMP = 6;
   localparam int NFLT = NCMP + 2;

   localparam int CI_H_BAT = 0;
   localparam int CI_L_GND = 1;
   localparam int CI_L_BAT = 2;
   localparam int CI_H_SUP = 3;
   localparam int CI_CROSS = 4;
   localparam int CI_OVV   = 5;
   localparam int EI_H_OPEN = 6;
   localparam int EI_L_OPEN = 7;

   // faults that make a given wire unusable (overvoltage counts for both)
   localparam logic [NFLT-1:0] MASK_H_BAD =
      NFLT'((1 << CI_H_BAT) | (1 << CI_H_SUP) | (1 << EI_H_OPEN) | (1 << CI_OVV));
   localparam logic [NFLT-1:0] MASK_L_BAD =
      NFLT'((1 << CI_L_GND) | (1 << CI_L_BAT) | (1 << CI_CROSS) | (1 << EI_L_OPEN) | (1 << CI_OVV));

   typedef enum logic [1:0] {
      WM_DUAL   = 2'd0,
      WM_H_ONLY = 2'd1,
      WM_L_ONLY = 2'd2,
      WM_NONE   = 2'd3
   } wire_mode_e;
endpackage

// File: rtl/cbfm_timefilt.sv
`timescale 1ns/1ps
module cbfm_timefilt #(
   parameter int unsigned DET_TICKS = 4,
   parameter int unsigned REC_TICKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cond,
   output logic flag
);
   localparam int unsigned MAXT = (DET_TICKS > REC_TICKS) ? DET_TICKS : REC_TICKS;
   localparam int CW = $clog2(MAXT + 1);
   localparam logic [CW-1:0] DLAST = CW'(DET_TICKS - 1);
   localparam logic [CW-1:0] RLAST = CW'(REC_TICKS - 1);

   if (DET_TICKS < 1 || REC_TICKS < 1) begin : g_bad_ticks
      $error("cbfm_timefilt: filter times must be at least one tick");
   end

   logic [CW-1:0] cnt;

   // one counter serves both directions: it runs while input and flag disagree
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
         cnt  <= '0;
      end else if (cond != flag) begin
         if (cnt == (flag ? RLAST : DLAST)) begin
            flag <= cond;
            cnt  <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else begin
         cnt <= '0;
      end
   end
endmodule

// File: rtl/cbfm_edgediff.sv
`timescale 1ns/1ps
module cbfm_edgediff #(
   parameter int EDGE_LIMIT = 3,
   parameter int EDGE_RECOV = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic canh_dom,
   input  logic canl_dom,
   output logic h_lost,
   output logic l_lost
);
   localparam int DW = $clog2(EDGE_LIMIT + 2) + 1;
   localparam int RW = $clog2(EDGE_RECOV + 1);
   localparam logic signed [DW-1:0] LIM_P = $signed(DW'(EDGE_LIMIT));
   localparam logic signed [DW-1:0] LIM_N = -LIM_P;
   localparam logic [RW-1:0] RLAST = RW'(EDGE_RECOV - 1);

   if (EDGE_LIMIT < 1 || EDGE_RECOV < 1) begin : g_bad_edge
      $error("cbfm_edgediff: limits must be at least one");
   end

   logic prev_h, prev_l;
   logic fall_h, fall_l;
   logic signed [DW-1:0] diff, nxt;
   logic [RW-1:0] rcnt;

   assign fall_h = prev_h & ~canh_dom;
   assign fall_l = prev_l & ~canl_dom;
   // positive difference: low wire ahead, high wire silent
   assign nxt = diff + $signed(DW'(fall_l)) - $signed(DW'(fall_h));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_h <= 1'b0;
         prev_l <= 1'b0;
         diff   <= '0;
         rcnt   <= '0;
         h_lost <= 1'b0;
         l_lost <= 1'b0;
      end else begin
         prev_h <= canh_dom;
         prev_l <= canl_dom;
         if (h_lost || l_lost) begin
            if (h_lost ? fall_h : fall_l) begin
               if (rcnt == RLAST) begin
                  h_lost <= 1'b0;
                  l_lost <= 1'b0;
                  diff   <= '0;
                  rcnt   <= '0;
               end else begin
                  rcnt <= rcnt + 1'b1;
               end
            end
         end else begin
            diff <= nxt;
            if (nxt > LIM_P) h_lost <= 1'b1;
            if (nxt < LIM_N) l_lost <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/cbfm_route.sv
`timescale 1ns/1ps
module cbfm_route
   import cbfm_pkg::*;
(
   input  logic [NFLT-1:0] flags,
   input  logic            canh_dom,
   input  logic            canl_dom,
   input  logic            txd_dom,
   input  logic            tx_blocked,
   output wire_mode_e      mode,
   output logic            rx_dom,
   output logic            drv_h,
   output logic            drv_l
);
   logic h_bad, l_bad, use_h, use_l;

   assign h_bad = |(flags & MASK_H_BAD);
   assign l_bad = |(flags & MASK_L_BAD);

   always_comb begin
      unique case ({h_bad, l_bad})
         2'b11:   mode = WM_NONE;
         2'b10:   mode = WM_L_ONLY;
         2'b01:   mode = WM_H_ONLY;
         default: mode = WM_DUAL;
      endcase
   end

   assign use_h  = (mode == WM_DUAL) || (mode == WM_H_ONLY);
   assign use_l  = (mode == WM_DUAL) || (mode == WM_L_ONLY);
   assign rx_dom = (use_h & canh_dom) | (use_l & canl_dom);
   assign drv_h  = txd_dom & ~tx_blocked & use_h;
   assign drv_l  = txd_dom & ~tx_blocked & use_l;
endmodule

// File: rtl/canbus_fault_monitor.sv
`timescale 1ns/1ps
module canbus_fault_monitor
   import cbfm_pkg::*;
#(
   parameter int unsigned DET_T [NCMP] = '{2000, 900, 900, 1800, 900, 32},
   parameter int unsigned REC_T [NCMP] = '{900, 30, 500, 900, 30, 16},
   parameter int unsigned TX_LIMIT = 1300,
   parameter int unsigned TX_REC   = 4,
   parameter int          EDGE_LIMIT = 3,
   parameter int          EDGE_RECOV = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            canh_dom,
   input  logic            canl_dom,
   input  logic [NCMP-1:0] cmp_cond,
   input  logic            txd_dom,
   output logic [NFLT-1:0] fault_flags,
   output logic [1:0]      wire_mode,
   output logic            rx_dom,
   output logic            drv_h,
   output logic            drv_l,
   output logic            tx_blocked
);
   wire_mode_e mode;

   for (genvar gi = 0; gi < NCMP; gi++) begin : g_cmp
      cbfm_timefilt #(
         .DET_TICKS(DET_T[gi]),
         .REC_TICKS(REC_T[gi])
      ) u_filt (
         .clk  (clk),
         .rst_n(rst_n),
         .cond (cmp_cond[gi]),
         .flag (fault_flags[gi])
      );
   end

   cbfm_edgediff #(
      .EDGE_LIMIT(EDGE_LIMIT),
      .EDGE_RECOV(EDGE_RECOV)
   ) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .canh_dom(canh_dom),
      .canl_dom(canl_dom),
      .h_lost  (fault_flags[EI_H_OPEN]),
      .l_lost  (fault_flags[EI_L_OPEN])
   );

   cbfm_timefilt #(
      .DET_TICKS(TX_LIMIT),
      .REC_TICKS(TX_REC)
   ) u_txto (
      .clk  (clk),
      .rst_n(rst_n),
      .cond (txd_dom),
      .flag (tx_blocked)
   );

   cbfm_route u_route (
      .flags     (fault_flags),
      .canh_dom  (canh_dom),
      .canl_dom  (canl_dom),
      .txd_dom   (txd_dom),
      .tx_blocked(tx_blocked),
      .mode      (mode),
      .rx_dom    (rx_dom),
      .drv_h     (drv_h),
      .drv_l     (drv_l)
   );

   assign wire_mode = mode;
endmodule

// File: rtl/cbfm_checker.sv
`timescale 1ns/1ps
module cbfm_checker
   import cbfm_pkg::*;
(
   input logic            clk,
   input logic            rst_n,
   input logic            canh_dom,
   input logic            canl_dom,
   input logic [NCMP-1:0] cmp_cond,
   input logic            txd_dom,
   input logic [NFLT-1:0] fault_flags,
   input logic [1:0]      wire_mode,
   input logic            rx_dom,
   input logic            drv_h,
   input logic            drv_l,
   input logic            tx_blocked
);
   for (genvar gi = 0; gi < NCMP; gi++) begin : g_cmp_chk
      AST_SET_NEEDS_COND: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(fault_flags[gi]) |-> $past(cmp_cond[gi])); // R2
      AST_CLEAR_NEEDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(fault_flags[gi]) |-> !$past(cmp_cond[gi])); // R3
   end

   AST_H_LOST_ON_L_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_flags[EI_H_OPEN]) |-> ($past(canl_dom, 2) && !$past(canl_dom))); // R4
   AST_L_LOST_ON_H_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_flags[EI_L_OPEN]) |-> ($past(canh_dom, 2) && !$past(canh_dom))); // R4
   AST_H_BACK_ON_H_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fault_flags[EI_H_OPEN]) |-> ($past(canh_dom, 2) && !$past(canh_dom))); // R5
   AST_L_BACK_ON_L_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fault_flags[EI_L_OPEN]) |-> ($past(canl_dom, 2) && !$past(canl_dom))); // R5
   AST_OVV_NO_WIRE: assert property (@(posedge clk) disable iff (!rst_n)
      fault_flags[CI_OVV] |-> (wire_mode == 2'd3)); // R6
   AST_RX_IDLE_NO_WIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (wire_mode == 2'd3) |-> !rx_dom); // R7
   AST_NO_DRIVE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      tx_blocked |-> (!drv_h && !drv_l)); // R8
   AST_TX_BLOCK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_blocked) |-> $past(txd_dom)); // R9
   AST_TX_BLOCK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_blocked) |-> !$past(txd_dom)); // R10
endmodule

bind canbus_fault_monitor cbfm_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .canh_dom   (canh_dom),
   .canl_dom   (canl_dom),
   .cmp_cond   (cmp_cond),
   .txd_dom    (txd_dom),
   .fault_flags(fault_flags),
   .wire_mode  (wire_mode),
   .rx_dom     (rx_dom),
   .drv_h      (drv_h),
   .drv_l      (drv_l),
   .tx_blocked (tx_blocked)
);

// File: tb/tb_canbus_fault_monitor.sv
`timescale 1ns/1ps
module tb_canbus_fault_monitor;
   localparam int unsigned TB_DET [6] = '{6, 4, 5, 7, 3, 2};
   localparam int unsigned TB_REC [6] = '{5, 3, 2, 4, 3, 2};
   localparam int unsigned TB_TXL = 10;
   localparam int unsigned TB_TXR = 3;

   // {index[6:4], full window[3], expected flag[2], expected mode[1:0]}
   localparam logic [6:0] VEC [12] = '{
      {3'd0, 1'b0, 1'b0, 2'd0}, {3'd0, 1'b1, 1'b1, 2'd2},
      {3'd1, 1'b0, 1'b0, 2'd0}, {3'd1, 1'b1, 1'b1, 2'd1},
      {3'd2, 1'b0, 1'b0, 2'd0}, {3'd2, 1'b1, 1'b1, 2'd1},
      {3'd3, 1'b0, 1'b0, 2'd0}, {3'd3, 1'b1, 1'b1, 2'd2},
      {3'd4, 1'b0, 1'b0, 2'd0}, {3'd4, 1'b1, 1'b1, 2'd1},
      {3'd5, 1'b0, 1'b0, 2'd0}, {3'd5, 1'b1, 1'b1, 2'd3}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       canh_dom = 1'b0, canl_dom = 1'b0, txd_dom = 1'b0;
   logic [5:0] cmp_cond = '0;
   logic [7:0] fault_flags;
   logic [1:0] wire_mode;
   logic       rx_dom, drv_h, drv_l, tx_blocked;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   canbus_fault_monitor #(
      .DET_T(TB_DET), .REC_T(TB_REC),
      .TX_LIMIT(TB_TXL), .TX_REC(TB_TXR),
      .EDGE_LIMIT(3), .EDGE_RECOV(3)
   ) dut (
      .clk(clk), .rst_n(rst_n), .canh_dom(canh_dom), .canl_dom(canl_dom),
      .cmp_cond(cmp_cond), .txd_dom(txd_dom), .fault_flags(fault_flags),
      .wire_mode(wire_mode), .rx_dom(rx_dom), .drv_h(drv_h), .drv_l(drv_l),
      .tx_blocked(tx_blocked)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      canh_dom = 1'b0; canl_dom = 1'b0; txd_dom = 1'b0; cmp_cond = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic pulse(input bit h, input bit l);
      canh_dom = h; canl_dom = l;
      @(negedge clk);
      canh_dom = 1'b0; canl_dom = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1 reset state
      chk("R1 flags", fault_flags, 0);
      chk("R1 mode", wire_mode, 0);
      chk("R1 blocked", tx_blocked, 0);
      chk("R1 rx", rx_dom, 0);

      // table walk: R2 qualify window, R6 mode mapping, R3 release
      for (int v = 0; v < 12; v++) begin
         int idx;
         bit full;
         idx  = int'(VEC[v][6:4]);
         full = VEC[v][3];
         cmp_cond = '0;
         cmp_cond[idx] = 1'b1;
         repeat (full ? TB_DET[idx] : TB_DET[idx] - 1) @(negedge clk);
         chk("R2 flag after window", fault_flags[idx], int'(VEC[v][2]));
         chk("R6 mode", wire_mode, int'(VEC[v][1:0]));
         cmp_cond = '0;
         if (full) begin
            repeat (TB_REC[idx] - 1) @(negedge clk);
            chk("R3 flag held before release", fault_flags[idx], 1);
            @(negedge clk);
            chk("R3 flag released", fault_flags[idx], 0);
         end else begin
            @(negedge clk);
         end
      end

      // R2 glitch restarts the qualify count (index 1, window 4)
      do_reset();
      cmp_cond[1] = 1'b1; repeat (3) @(negedge clk);
      cmp_cond[1] = 1'b0; @(negedge clk);
      cmp_cond[1] = 1'b1; repeat (3) @(negedge clk);
      chk("R2 restart after gap", fault_flags[1], 0);
      @(negedge clk);
      chk("R2 set after full run", fault_flags[1], 1);

      // R3 reappearance restarts the release count (index 2, release 2)
      do_reset();
      cmp_cond[2] = 1'b1; repeat (5) @(negedge clk);
      chk("R3 precondition set", fault_flags[2], 1);
      cmp_cond[2] = 1'b0; @(negedge clk);
      cmp_cond[2] = 1'b1; @(negedge clk);
      cmp_cond[2] = 1'b0; @(negedge clk);
      chk("R3 restart on return", fault_flags[2], 1);
      @(negedge clk);
      chk("R3 cleared", fault_flags[2], 0);

      // R4 / R5 / R6 edge difference on the high wire
      do_reset();
      repeat (3) pulse(1'b0, 1'b1);
      chk("R4 three unmatched edges", fault_flags[6], 0);
      pulse(1'b0, 1'b1);
      chk("R4 fourth unmatched edge", fault_flags[6], 1);
      chk("R6 high lost mode", wire_mode, 2);
      repeat (2) pulse(1'b1, 1'b0);
      chk("R5 two recovery edges", fault_flags[6], 1);
      pulse(1'b1, 1'b0);
      chk("R5 third recovery edge", fault_flags[6], 0);
      repeat (3) pulse(1'b0, 1'b1);
      chk("R5 difference restarted", fault_flags[6], 0);

      // R4 mirror on the low wire
      do_reset();
      repeat (4) pulse(1'b1, 1'b0);
      chk("R4 low lost", fault_flags[7], 1);
      chk("R6 low lost mode", wire_mode, 1);

      // R4 matched edges never build a difference
      do_reset();
      repeat (8) pulse(1'b1, 1'b1);
      chk("R4 matched edges", fault_flags, 0);

      // R7 receive path per mode
      do_reset();
      canh_dom = 1'b1; #1;
      chk("R7 dual high", rx_dom, 1);
      canh_dom = 1'b0; canl_dom = 1'b1; #1;
      chk("R7 dual low", rx_dom, 1);
      do_reset();
      cmp_cond[0] = 1'b1; repeat (6) @(negedge clk);
      canh_dom = 1'b1; #1;
      chk("R7 low-only ignores high", rx_dom, 0);
      canl_dom = 1'b1; #1;
      chk("R7 low-only follows low", rx_dom, 1);
      do_reset();
      cmp_cond[5] = 1'b1; repeat (2) @(negedge clk);
      canh_dom = 1'b1; canl_dom = 1'b1; #1;
      chk("R7 no wire recessive", rx_dom, 0);

      // R8 driver enables per mode
      do_reset();
      txd_dom = 1'b1; #1;
      chk("R8 dual drv_h", drv_h, 1);
      chk("R8 dual drv_l", drv_l, 1);
      txd_dom = 1'b0;
      do_reset();
      cmp_cond[1] = 1'b1; repeat (4) @(negedge clk);
      txd_dom = 1'b1; #1;
      chk("R8 high-only drv_h", drv_h, 1);
      chk("R8 high-only drv_l", drv_l, 0);

      // R9 / R10 transmit timeout
      do_reset();
      txd_dom = 1'b1;
      repeat (TB_TXL - 1) @(negedge clk);
      chk("R9 not yet blocked", tx_blocked, 0);
      chk("R9 still driving", drv_h, 1);
      @(negedge clk);
      chk("R9 blocked", tx_blocked, 1);
      chk("R8 blocked no drive", drv_h, 0);
      txd_dom = 1'b0;
      repeat (TB_TXR - 1) @(negedge clk);
      chk("R10 held", tx_blocked, 1);
      @(negedge clk);
      chk("R10 released", tx_blocked, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule